// File: doc/BRIEF.md
# Reassembly Event Status Aggregator

This block gathers the rollover events raised by the per-port counters of a cell reassembly engine and turns them into one status register and one service request. Each clock, a fixed number of event lanes can each present a pulse carrying the TDM port that raised it and a two-bit event kind. The kinds are misinserted-cell, buffer-underrun, buffer-overrun and late-cell counter rollover. Each kind has its own enable bit. An enabled event sets a sticky aggregate flag and records the port that raised it. While the flag is clear, the port field holds the illegal value 1Fh.

The block also counts received cells on a single strobe in a 16-bit read-only counter. When that counter wraps, a second sticky flag is set. Each sticky flag passes through its own service enable, and the two gated results are ORed into a registered summary service bit. That bit feeds a chip-level main status register. Software reads and writes the enable and status registers through a simple single-cycle register port, and clears either flag by writing 0 to it.

Top module: `reasm_event_aggr`

## Requirements
- R1: After reset the enable register (address 0) reads 0000h, the status register (address 1) reads 001Fh, the counter (address 2) reads 0000h, address 3 reads 0000h and `srv_out` is 0.
- R2: Event kind codes are 0 = misinserted, 1 = underrun, 2 = overrun and 3 = late. They map to enable register bits 0 to 3. An event whose kind enable is 0 leaves the status register unchanged.
- R3: An enabled event sets status bit 8 and loads its port into status bits 4:0 on the next clock edge. A later enabled event overwrites the port.
- R4: Writing status with bit 8 = 0 clears bit 8 and returns bits 4:0 to 1Fh. Writing bit 8 = 1 changes neither. While bit 8 is 0, bits 4:0 read 1Fh.
- R5: When several enabled events arrive in one cycle, the port field takes the lowest port number among them. Disabled events in the same cycle are ignored.
- R6: An enabled event in the same cycle as a clear write wins: bit 8 stays set and bits 4:0 take the new port.
- R7: `srv_out` equals (status bit 8 AND enable bit 4) OR (status bit 9 AND enable bit 5), registered: it follows a change of status or enable by one clock edge.
- R8: Each cycle with `cell_rx` high adds one to the counter read at address 2. With `cell_rx` low the counter holds.
- R9: Writes to address 2 or address 3 change no register.
- R10: On a `cell_rx` with the counter at FFFFh, the counter wraps to 0000h, keeps counting and sets status bit 9. Writing status with bit 9 = 0 clears that bit.
- R11: Reserved bits read zero: enable bits 15:6, and status bits 15:10 and 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | LANES | One valid bit per event lane |
| evt_port | input | LANES*PORT_W | Port number per lane, lane 0 in the low bits |
| evt_kind | input | LANES*2 | Event kind code per lane, lane 0 in the low bits |
| cell_rx | input | 1 | Received-cell strobe, one count per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Combinational read data for `reg_addr` |
| srv_out | output | 1 | Registered summary service request |

## Verification
Several properties are checked on every cycle. The port field reads the sentinel whenever the aggregate flag is clear, and reserved bits read zero. The service bit lags its gated sources by exactly one edge. The counter steps by one per strobe and otherwise holds, and a wrap always raises the rollover flag. A quiet cycle never sets the aggregate flag, and a clear write with no event always drops it. Other behaviour only shows up in the directed scenarios: the kind-to-enable mapping, the choice of the lowest port among simultaneous events, the event winning over a same-cycle clear, writes of 1 being ignored, and the counter's read-only address.

// File: rtl/reasm_aggr_pkg.sv
package reasm_aggr_pkg;

    typedef enum logic [1:0] {
        EVT_MISINS   = 2'd0,
        EVT_UNDERRUN = 2'd1,
        EVT_OVERRUN  = 2'd2,
        EVT_LATE     = 2'd3
    } evt_kind_e;

    localparam int unsigned KIND_W     = 2;
    localparam int unsigned NUM_KINDS  = 4;
    localparam int unsigned REGADDR_W  = 2;

    localparam logic [REGADDR_W-1:0] RA_ENABLE = 2'd0;
    localparam logic [REGADDR_W-1:0] RA_STATUS = 2'd1;
    localparam logic [REGADDR_W-1:0] RA_COUNT  = 2'd2;

    localparam int unsigned EN_SRV_EVT_BIT = 4;
    localparam int unsigned EN_SRV_CNT_BIT = 5;
    localparam int unsigned ST_EVT_BIT     = 8;
    localparam int unsigned ST_CNT_BIT     = 9;

endpackage

// File: rtl/reasm_evt_select.sv
module reasm_evt_select
    import reasm_aggr_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned PORT_W = 5
) (
    input  logic [LANES-1:0]        valid,
    input  logic [LANES*PORT_W-1:0] port,
    input  logic [LANES*KIND_W-1:0] kind,
    input  logic [NUM_KINDS-1:0]    kind_en,
    output logic                    hit,
    output logic [PORT_W-1:0]       hit_port
);

    logic [PORT_W-1:0] lane_port [LANES];
    logic [LANES-1:0]  lane_live;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [KIND_W-1:0] lane_kind;
        assign lane_kind    = kind[g*KIND_W +: KIND_W];
        assign lane_port[g] = port[g*PORT_W +: PORT_W];
        assign lane_live[g] = valid[g] & kind_en[lane_kind];
    end

    always_comb begin
        hit      = 1'b0;
        hit_port = '1;
        for (int i = 0; i < LANES; i++) begin
            if (lane_live[i] && (!hit || (lane_port[i] < hit_port))) begin
                hit      = 1'b1;
                hit_port = lane_port[i];
            end
        end
    end

endmodule

// File: rtl/reasm_cell_cnt.sv
module reasm_cell_cnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (strobe) begin
            cnt_d = cnt_q + 1'b1;
            wrap  = &cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/reasm_event_aggr.sv
module reasm_event_aggr
    import reasm_aggr_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned PORT_W = 5,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned REG_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        evt_valid,
    input  logic [LANES*PORT_W-1:0] evt_port,
    input  logic [LANES*2-1:0]      evt_kind,
    input  logic                    cell_rx,
    input  logic                    reg_wr,
    input  logic [1:0]              reg_addr,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    output logic                    srv_out
);

    typedef struct packed {
        logic [NUM_KINDS-1:0] kind_en;
        logic                 srv_en_evt;
        logic                 srv_en_cnt;
        logic                 evt_stat;
        logic                 cnt_stat;
        logic [PORT_W-1:0]    port;
        logic                 srv;
    } aggr_state_t;

    localparam aggr_state_t RESET_STATE = '{
        kind_en:    '0,
        srv_en_evt: 1'b0,
        srv_en_cnt: 1'b0,
        evt_stat:   1'b0,
        cnt_stat:   1'b0,
        port:       '1,
        srv:        1'b0
    };

    aggr_state_t       st_d, st_q;
    logic              sel_hit;
    logic [PORT_W-1:0] sel_port;
    logic [CNT_W-1:0]  cell_cnt;
    logic              cell_wrap;

    reasm_evt_select #(
        .LANES  (LANES),
        .PORT_W (PORT_W)
    ) u_select (
        .valid    (evt_valid),
        .port     (evt_port),
        .kind     (evt_kind),
        .kind_en  (st_q.kind_en),
        .hit      (sel_hit),
        .hit_port (sel_port)
    );

    reasm_cell_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cell_rx),
        .count  (cell_cnt),
        .wrap   (cell_wrap)
    );

    always_comb begin
        st_d = st_q;

        if (reg_wr && (reg_addr == RA_ENABLE)) begin
            st_d.kind_en    = reg_wdata[NUM_KINDS-1:0];
            st_d.srv_en_evt = reg_wdata[EN_SRV_EVT_BIT];
            st_d.srv_en_cnt = reg_wdata[EN_SRV_CNT_BIT];
        end

        if (reg_wr && (reg_addr == RA_STATUS)) begin
            if (!reg_wdata[ST_EVT_BIT]) begin
                st_d.evt_stat = 1'b0;
                st_d.port     = '1;
            end
            if (!reg_wdata[ST_CNT_BIT]) begin
                st_d.cnt_stat = 1'b0;
            end
        end

        // a fresh event or wrap outranks a same-cycle software clear
        if (sel_hit) begin
            st_d.evt_stat = 1'b1;
            st_d.port     = sel_port;
        end
        if (cell_wrap) begin
            st_d.cnt_stat = 1'b1;
        end

        st_d.srv = (st_q.evt_stat & st_q.srv_en_evt) |
                   (st_q.cnt_stat & st_q.srv_en_cnt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_ENABLE: begin
                reg_rdata[NUM_KINDS-1:0]  = st_q.kind_en;
                reg_rdata[EN_SRV_EVT_BIT] = st_q.srv_en_evt;
                reg_rdata[EN_SRV_CNT_BIT] = st_q.srv_en_cnt;
            end
            RA_STATUS: begin
                reg_rdata[PORT_W-1:0]  = st_q.port;
                reg_rdata[ST_EVT_BIT]  = st_q.evt_stat;
                reg_rdata[ST_CNT_BIT]  = st_q.cnt_stat;
            end
            RA_COUNT: begin
                reg_rdata[CNT_W-1:0] = cell_cnt;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign srv_out = st_q.srv;

endmodule

// File: rtl/reasm_event_aggr_chk.sv
module reasm_event_aggr_chk #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned PORT_W = 5,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned REG_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] evt_valid,
    input logic             cell_rx,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             srv_out,
    input logic [CNT_W-1:0] cnt,
    input logic             evt_stat,
    input logic             cnt_stat,
    input logic             srv_en_evt,
    input logic             srv_en_cnt
);

    assert_sentinel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd1 && !reg_rdata[8]) |-> (reg_rdata[PORT_W-1:0] == {PORT_W{1'b1}}));

    assert_rsvd_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[REG_W-1:6] == '0));

    assert_rsvd_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd1) |-> (reg_rdata[REG_W-1:10] == '0 && reg_rdata[7:PORT_W] == '0));

    assert_srv_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (srv_out == $past((evt_stat & srv_en_evt) | (cnt_stat & srv_en_cnt))));

    assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cell_rx |=> (cnt == $past(cnt) + 1'b1));

    assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_rx |=> $stable(cnt));

    assert_wrap_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_rx && (&cnt)) |=> cnt_stat);

    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_stat && evt_valid == '0) |=> !evt_stat);

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && !reg_wdata[8] && evt_valid == '0) |=> !evt_stat);

endmodule

bind reasm_event_aggr reasm_event_aggr_chk #(
    .LANES  (LANES),
    .PORT_W (PORT_W),
    .CNT_W  (CNT_W),
    .REG_W  (REG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .cell_rx    (cell_rx),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .srv_out    (srv_out),
    .cnt        (cell_cnt),
    .evt_stat   (st_q.evt_stat),
    .cnt_stat   (st_q.cnt_stat),
    .srv_en_evt (st_q.srv_en_evt),
    .srv_en_cnt (st_q.srv_en_cnt)
);

// File: tb/tb_reasm_event_aggr.sv
module tb_reasm_event_aggr;

    localparam int LANES  = 4;
    localparam int PORT_W = 5;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [LANES-1:0]        evt_valid = '0;
    logic [LANES*PORT_W-1:0] evt_port = '0;
    logic [LANES*2-1:0]      evt_kind = '0;
    logic                    cell_rx = 1'b0;
    logic                    reg_wr = 1'b0;
    logic [1:0]              reg_addr = 2'd0;
    logic [15:0]             reg_wdata = '0;
    logic [15:0]             reg_rdata;
    logic                    srv_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    reasm_event_aggr #(.LANES(LANES), .PORT_W(PORT_W)) dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_port(evt_port),
        .evt_kind(evt_kind), .cell_rx(cell_rx), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .srv_out(srv_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [1:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic set_lane(input int lane, input int port, input int kind);
        evt_valid[lane] = 1'b1;
        evt_port[lane*PORT_W +: PORT_W] = PORT_W'(port);
        evt_kind[lane*2 +: 2] = 2'(kind);
    endtask

    task automatic end_events();
        @(negedge clk);
        evt_valid = '0; evt_port = '0; evt_kind = '0;
    endtask

    task automatic fire(input int lane, input int port, input int kind);
        set_lane(lane, port, kind);
        end_events();
    endtask

    task automatic t_reset();
        chk_reg("R1 enable", 2'd0, 16'h0000);
        chk_reg("R1 status", 2'd1, 16'h001F);
        chk_reg("R1 count", 2'd2, 16'h0000);
        chk_reg("R1 addr3", 2'd3, 16'h0000);
        chk("R1 srv", {15'd0, srv_out}, 16'h0000);
    endtask

    task automatic t_masked();
        for (int k = 0; k < 4; k++) begin
            fire(0, 3, k);
            chk_reg("R2 all kinds masked", 2'd1, 16'h001F);
        end
        wr(2'd0, 16'h0002);
        fire(1, 3, 0);
        chk_reg("R2 misinserted masked", 2'd1, 16'h001F);
    endtask

    task automatic t_unmasked();
        fire(0, 7, 1);
        chk_reg("R3 underrun sets", 2'd1, 16'h0107);
        fire(0, 2, 2);
        chk_reg("R2 overrun masked keeps port", 2'd1, 16'h0107);
        wr(2'd0, 16'h000F);
        fire(2, 20, 3);
        chk_reg("R3 later event overwrites", 2'd1, 16'h0114);
    endtask

    task automatic t_clear();
        wr(2'd1, 16'h0000);
        chk_reg("R4 clear", 2'd1, 16'h001F);
        wr(2'd1, 16'h0100);
        chk_reg("R4 write one while clear", 2'd1, 16'h001F);
        fire(3, 5, 0);
        chk_reg("R3 misinserted sets", 2'd1, 16'h0105);
        wr(2'd1, 16'h0100);
        chk_reg("R4 write one while set", 2'd1, 16'h0105);
        wr(2'd1, 16'h0000);
        chk_reg("R4 clear again", 2'd1, 16'h001F);
    endtask

    task automatic t_lowest();
        wr(2'd0, 16'h0002);
        set_lane(0, 1, 0);
        set_lane(1, 9, 1);
        set_lane(2, 4, 1);
        set_lane(3, 12, 1);
        end_events();
        chk_reg("R5 lowest enabled port", 2'd1, 16'h0104);
        wr(2'd1, 16'h0000);
    endtask

    task automatic t_race();
        fire(0, 10, 1);
        chk_reg("R6 setup", 2'd1, 16'h010A);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0000;
        set_lane(3, 6, 1);
        end_events();
        reg_wr = 1'b0;
        chk_reg("R6 event beats clear", 2'd1, 16'h0106);
        wr(2'd1, 16'h0000);
        chk_reg("R6 cleared", 2'd1, 16'h001F);
    endtask

    task automatic t_srv();
        wr(2'd0, 16'h0012);
        @(negedge clk);
        chk("R7 srv idle", {15'd0, srv_out}, 16'h0000);
        fire(1, 3, 1);
        chk("R7 srv lags status", {15'd0, srv_out}, 16'h0000);
        @(negedge clk);
        chk("R7 srv raised", {15'd0, srv_out}, 16'h0001);
        wr(2'd0, 16'h0002);
        chk("R7 srv lags enable", {15'd0, srv_out}, 16'h0001);
        @(negedge clk);
        chk("R7 srv dropped", {15'd0, srv_out}, 16'h0000);
        wr(2'd1, 16'h0000);
    endtask

    task automatic t_count();
        cell_rx = 1'b1;
        repeat (5) @(negedge clk);
        cell_rx = 1'b0;
        chk_reg("R8 five cells", 2'd2, 16'd5);
        cell_rx = 1'b1;
        @(negedge clk);
        cell_rx = 1'b0;
        repeat (3) @(negedge clk);
        chk_reg("R8 hold when idle", 2'd2, 16'd6);
        wr(2'd2, 16'h1234);
        chk_reg("R9 counter read-only", 2'd2, 16'd6);
        wr(2'd3, 16'hFFFF);
        chk_reg("R9 addr3 write ignored", 2'd0, 16'h0002);
    endtask

    task automatic t_wrap();
        cell_rx = 1'b1;
        repeat (65535 - 6) @(negedge clk);
        cell_rx = 1'b0;
        chk_reg("R10 at top", 2'd2, 16'hFFFF);
        chk_reg("R10 no rollover yet", 2'd1, 16'h001F);
        cell_rx = 1'b1;
        @(negedge clk);
        cell_rx = 1'b0;
        chk_reg("R10 wrapped", 2'd2, 16'h0000);
        chk_reg("R10 rollover flag", 2'd1, 16'h021F);
        cell_rx = 1'b1;
        @(negedge clk);
        cell_rx = 1'b0;
        chk_reg("R10 keeps counting", 2'd2, 16'h0001);
        wr(2'd0, 16'h0020);
        chk("R7 cnt srv lags", {15'd0, srv_out}, 16'h0000);
        @(negedge clk);
        chk("R7 cnt srv raised", {15'd0, srv_out}, 16'h0001);
        wr(2'd1, 16'h0100);
        chk_reg("R10 rollover cleared", 2'd1, 16'h001F);
        @(negedge clk);
        chk("R7 cnt srv dropped", {15'd0, srv_out}, 16'h0000);
    endtask

    task automatic t_reserved();
        wr(2'd0, 16'hFFFF);
        chk_reg("R11 enable reserved", 2'd0, 16'h003F);
        fire(2, 31, 2);
        chk_reg("R11 status reserved", 2'd1, 16'h011F);
        chk_reg("R11 addr3 zero", 2'd3, 16'h0000);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked();
        t_unmasked();
        t_clear();
        t_lowest();
        t_race();
        t_srv();
        t_count();
        t_wrap();
        t_reserved();
        summary();
        $finish;
    end

endmodule